// File: doc/BRIEF.md
# 8-bit ALU with status flags

This unit is the arithmetic and logic stage of a small RISC core. Each cycle in which `op_valid` is high, it takes two 8-bit operands and a 5-bit operation code. It forms a result and a new set of status flags, and registers both on the next rising clock edge. The carry used by the carry-chained operations is read from the unit's own status register, so successive bytes of a wide add, subtract or compare chain together without outside help.

Each operation carries a write mask that names the flags it affects. Only those flags change, and every other flag keeps its value. As a result, an increment, a decrement or a logic operation leaves the carry intact. The compare-with-carry operation keeps the zero flag sticky, so a wide equality test across several bytes works. The compare operations update flags but write no result. A set port and a clear port let any single flag be forced directly.

The six flags are held at fixed bit positions of `flags_q`: carry C at bit 0, zero Z at bit 1, negative N at bit 2, overflow V at bit 3, sign S at bit 4 and half-carry H at bit 5.

Top module: `alu8_unit`

## Requirements
- R1: ADD (code 0) gives a+b and ADC (code 1) gives a+b+C. Both write the result and set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to result bit 7 and Z to (result==0).
- R2: SUB (code 2) gives a−b and SBC (code 3) gives a−b−C. Both write the result and set C and H to the borrows out of bits 7 and 3, V to signed overflow, N to bit 7 and Z to (result==0). For SBC, Z is described in R4.
- R3: CMP (code 4) and CPC (code 5) update C, Z, N, V, S and H exactly as SUB and SBC would. They leave `res_q` unchanged and keep `res_wr` low.
- R4: For SBC and CPC, Z becomes 0 when the difference is nonzero and otherwise keeps its previous value.
- R5: AND (code 6), OR (code 7) and XOR (code 8) write the bitwise result, clear V, set N and Z from the result, and leave C and H unchanged.
- R6: INC (code 11) gives a+1 and DEC (code 12) gives a−1. Both update only Z, N, V and S, and leave C and H unchanged. V is 1 exactly when INC starts from 0x7F or DEC starts from 0x80.
- R7: COM (code 9) gives 0xFF−a, sets C to 1, clears V and leaves H unchanged. NEG (code 10) gives 0x00−a and updates C, Z, N, V and H as a subtraction from zero.
- R8: LSL (code 13) and ROL (code 14) shift left, moving bit 7 into C. LSL fills bit 0 with 0 and ROL fills it with the old C. V is N xor C after the shift, and H is unchanged.
- R9: LSR (code 15), ROR (code 16) and ASR (code 17) shift right, moving bit 0 into C. Bit 7 is filled with 0 for LSR, with the old C for ROR, and with the old bit 7 for ASR. V is N xor C after the shift, and H is unchanged.
- R10: SWAP (code 18) exchanges the two nibbles, writes the result and changes no flag.
- R11: With `op_valid` low, `flag_set_en` alone sets and `flag_clr_en` alone clears the flag at bit position `flag_idx`. Both at once, an index of 6 or 7, or a high `op_valid` in the same cycle makes the port have no effect.
- R12: Results and flags change on the first rising edge after `op_valid` is sampled high. `res_wr` is high for exactly the cycles whose result was written. Codes 19 to 31, or a low `op_valid`, change nothing.
- R13: Reset (active-low `rst_n`) clears `res_q`, `res_wr` and all six flags.
- R14: S equals N xor V after every operation that writes V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the operation on the operand inputs this cycle |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| flag_set_en | input | 1 | Set the flag selected by `flag_idx` |
| flag_clr_en | input | 1 | Clear the flag selected by `flag_idx` |
| flag_idx | input | 3 | Flag bit position for the set and clear ports |
| res_q | output | 8 | Registered result of the last writing operation |
| res_wr | output | 1 | High for one cycle after a result was written |
| flags_q | output | 6 | Status flags {H,S,V,N,Z,C} |

## Verification
Every effect of this block, whether a new result, a `res_wr` pulse, an operation's flag update or a set or clear through the flag ports, is due one rising edge after the stimulus is sampled. No effect appears later than that. The bench applies each stimulus on a falling edge, waits through exactly one rising edge, and samples on the following falling edge. It removes the stimulus at that same moment, so each check sees one update and no drift. The expected flags are carried forward in the bench from one operation to the next, so a flag that an operation must leave alone is checked against the value it held before.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 6;
    localparam int IDX_W  = 3;

    // flag bit positions
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;

    // per-class flag write masks
    localparam logic [FLAG_W-1:0] MSK_ARITH = FLAG_W'((1 << F_C) | (1 << F_Z) | (1 << F_N) |
                                                      (1 << F_V) | (1 << F_S) | (1 << F_H));
    localparam logic [FLAG_W-1:0] MSK_LOGIC = FLAG_W'((1 << F_Z) | (1 << F_N) | (1 << F_V) |
                                                      (1 << F_S));
    localparam logic [FLAG_W-1:0] MSK_SHIFT = FLAG_W'((1 << F_C) | (1 << F_Z) | (1 << F_N) |
                                                      (1 << F_V) | (1 << F_S));

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 5'd0,
        ALU_ADC  = 5'd1,
        ALU_SUB  = 5'd2,
        ALU_SBC  = 5'd3,
        ALU_CMP  = 5'd4,
        ALU_CPC  = 5'd5,
        ALU_AND  = 5'd6,
        ALU_OR   = 5'd7,
        ALU_XOR  = 5'd8,
        ALU_COM  = 5'd9,
        ALU_NEG  = 5'd10,
        ALU_INC  = 5'd11,
        ALU_DEC  = 5'd12,
        ALU_LSL  = 5'd13,
        ALU_ROL  = 5'd14,
        ALU_LSR  = 5'd15,
        ALU_ROR  = 5'd16,
        ALU_ASR  = 5'd17,
        ALU_SWAP = 5'd18
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             c_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] r_o,
    output logic             co_o,
    output logic             ho_o,
    output logic             vo_o
);
    localparam int HB = WIDTH / 2;

    logic [WIDTH:0] full;
    logic [HB:0]    half;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, x_i} - {1'b0, y_i} - {{WIDTH{1'b0}}, c_i};
            half = {1'b0, x_i[HB-1:0]} - {1'b0, y_i[HB-1:0]} - {{HB{1'b0}}, c_i};
        end else begin
            full = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, c_i};
            half = {1'b0, x_i[HB-1:0]} + {1'b0, y_i[HB-1:0]} + {{HB{1'b0}}, c_i};
        end
    end

    assign r_o  = full[WIDTH-1:0];
    assign co_o = full[WIDTH];
    assign ho_o = half[HB];

    // signed overflow from operand and result sign bits
    always_comb begin
        if (sub_i)
            vo_o = (x_i[WIDTH-1] != y_i[WIDTH-1]) && (r_o[WIDTH-1] != x_i[WIDTH-1]);
        else
            vo_o = (x_i[WIDTH-1] == y_i[WIDTH-1]) && (r_o[WIDTH-1] != x_i[WIDTH-1]);
    end

endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] r_o,
    output logic             c_o
);
    always_comb begin
        r_o = a_i;
        c_o = c_i;
        case (op_i)
            ALU_LSL: begin
                r_o = {a_i[WIDTH-2:0], 1'b0};
                c_o = a_i[WIDTH-1];
            end
            ALU_ROL: begin
                r_o = {a_i[WIDTH-2:0], c_i};
                c_o = a_i[WIDTH-1];
            end
            ALU_LSR: begin
                r_o = {1'b0, a_i[WIDTH-1:1]};
                c_o = a_i[0];
            end
            ALU_ROR: begin
                r_o = {c_i, a_i[WIDTH-1:1]};
                c_o = a_i[0];
            end
            ALU_ASR: begin
                r_o = {a_i[WIDTH-1], a_i[WIDTH-1:1]};
                c_o = a_i[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] upd_msk,
    input  logic [FLAG_W-1:0] upd_val,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  idx,
    output logic [FLAG_W-1:0] flags_o
);
    logic port_ok;

    // the direct ports act only in a cycle without an operation
    assign port_ok = !upd_en && (set_en ^ clr_en);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        logic hit;
        logic bit_q;

        assign hit = port_ok && (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (upd_en && upd_msk[i])
                bit_q <= upd_val[i];
            else if (hit)
                bit_q <= set_en;
        end

        assign flags_o[i] = bit_q;
    end

endmodule

// File: rtl/alu8_unit.sv
`timescale 1ns/1ps
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic              flag_set_en,
    input  logic              flag_clr_en,
    input  logic [IDX_W-1:0]  flag_idx,
    output logic [WIDTH-1:0]  res_q,
    output logic              res_wr,
    output logic [FLAG_W-1:0] flags_q
);
    localparam int HB = WIDTH / 2;

    alu_op_e op;
    logic    c_cur;
    logic    z_cur;

    assign op    = alu_op_e'(op_sel);
    assign c_cur = flags_q[F_C];
    assign z_cur = flags_q[F_Z];

    // adder/subtractor operand steering
    logic [WIDTH-1:0] as_x, as_y, as_r;
    logic             as_c, as_sub, as_co, as_ho, as_vo;

    always_comb begin
        as_x   = opnd_a;
        as_y   = opnd_b;
        as_c   = 1'b0;
        as_sub = 1'b0;
        case (op)
            ALU_ADC: as_c = c_cur;
            ALU_SUB, ALU_CMP: as_sub = 1'b1;
            ALU_SBC, ALU_CPC: begin
                as_sub = 1'b1;
                as_c   = c_cur;
            end
            ALU_NEG: begin
                as_x   = '0;
                as_y   = opnd_a;
                as_sub = 1'b1;
            end
            ALU_INC: as_y = WIDTH'(1);
            ALU_DEC: begin
                as_y   = WIDTH'(1);
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) addsub_i (
        .x_i   (as_x),
        .y_i   (as_y),
        .c_i   (as_c),
        .sub_i (as_sub),
        .r_o   (as_r),
        .co_o  (as_co),
        .ho_o  (as_ho),
        .vo_o  (as_vo)
    );

    logic [WIDTH-1:0] sh_r;
    logic             sh_c;

    alu8_shift #(.WIDTH(WIDTH)) shift_i (
        .op_i (op),
        .a_i  (opnd_a),
        .c_i  (c_cur),
        .r_o  (sh_r),
        .c_o  (sh_c)
    );

    // result select and flag generation
    logic [WIDTH-1:0]  nxt_res;
    logic              nxt_we;
    logic [FLAG_W-1:0] fl_val;
    logic [FLAG_W-1:0] fl_msk;

    always_comb begin
        nxt_res = opnd_a;
        nxt_we  = 1'b0;
        fl_val  = '0;
        fl_msk  = '0;
        case (op)
            ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC, ALU_CMP, ALU_CPC, ALU_NEG: begin
                nxt_res      = as_r;
                nxt_we       = (op != ALU_CMP) && (op != ALU_CPC);
                fl_val[F_C]  = as_co;
                fl_val[F_H]  = as_ho;
                fl_val[F_V]  = as_vo;
                fl_val[F_N]  = as_r[WIDTH-1];
                if (op == ALU_SBC || op == ALU_CPC)
                    fl_val[F_Z] = (as_r == '0) && z_cur;
                else
                    fl_val[F_Z] = (as_r == '0);
                fl_msk       = MSK_ARITH;
            end
            ALU_AND, ALU_OR, ALU_XOR: begin
                if (op == ALU_AND)
                    nxt_res = opnd_a & opnd_b;
                else if (op == ALU_OR)
                    nxt_res = opnd_a | opnd_b;
                else
                    nxt_res = opnd_a ^ opnd_b;
                nxt_we      = 1'b1;
                fl_val[F_N] = nxt_res[WIDTH-1];
                fl_val[F_Z] = (nxt_res == '0);
                fl_msk      = MSK_LOGIC;
            end
            ALU_COM: begin
                nxt_res     = ~opnd_a;
                nxt_we      = 1'b1;
                fl_val[F_C] = 1'b1;
                fl_val[F_N] = nxt_res[WIDTH-1];
                fl_val[F_Z] = (nxt_res == '0);
                fl_msk      = MSK_SHIFT;
            end
            ALU_INC, ALU_DEC: begin
                nxt_res     = as_r;
                nxt_we      = 1'b1;
                fl_val[F_V] = as_vo;
                fl_val[F_N] = as_r[WIDTH-1];
                fl_val[F_Z] = (as_r == '0);
                fl_msk      = MSK_LOGIC;
            end
            ALU_LSL, ALU_ROL, ALU_LSR, ALU_ROR, ALU_ASR: begin
                nxt_res     = sh_r;
                nxt_we      = 1'b1;
                fl_val[F_C] = sh_c;
                fl_val[F_N] = sh_r[WIDTH-1];
                fl_val[F_V] = sh_r[WIDTH-1] ^ sh_c;
                fl_val[F_Z] = (sh_r == '0);
                fl_msk      = MSK_SHIFT;
            end
            ALU_SWAP: begin
                nxt_res = {opnd_a[HB-1:0], opnd_a[WIDTH-1:HB]};
                nxt_we  = 1'b1;
            end
            default: ;
        endcase
        fl_val[F_S] = fl_val[F_N] ^ fl_val[F_V];
    end

    alu8_flagreg flagreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid),
        .upd_msk (fl_msk),
        .upd_val (fl_val),
        .set_en  (flag_set_en),
        .clr_en  (flag_clr_en),
        .idx     (flag_idx),
        .flags_o (flags_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            res_wr <= 1'b0;
        end else begin
            res_wr <= op_valid && nxt_we;
            if (op_valid && nxt_we)
                res_q <= nxt_res;
        end
    end

endmodule

// File: rtl/alu8_unit_chk.sv
`timescale 1ns/1ps
module alu8_unit_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_sel,
    input logic              flag_set_en,
    input logic              flag_clr_en,
    input logic [IDX_W-1:0]  flag_idx,
    input logic [WIDTH-1:0]  res_q,
    input logic              res_wr,
    input logic [FLAG_W-1:0] flags_q
);
    logic is_cmp, keeps_c, z_from_res, writes_v;

    assign is_cmp     = (op_sel == ALU_CMP) || (op_sel == ALU_CPC);
    assign keeps_c    = (op_sel == ALU_AND) || (op_sel == ALU_OR) || (op_sel == ALU_XOR) ||
                        (op_sel == ALU_INC) || (op_sel == ALU_DEC);
    assign z_from_res = (op_sel == ALU_ADD) || (op_sel == ALU_SUB) || (op_sel == ALU_AND) ||
                        (op_sel == ALU_OR)  || (op_sel == ALU_XOR) || (op_sel == ALU_COM) ||
                        (op_sel == ALU_NEG) || (op_sel == ALU_INC) || (op_sel == ALU_DEC);
    assign writes_v   = (op_sel <= ALU_ASR);

    // R3
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_cmp |=> !res_wr && $stable(res_q));

    // R5
    carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && keeps_c |=> $stable(flags_q[F_C]));

    // R7
    com_sets_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel == ALU_COM) |=> flags_q[F_C]);

    // R10
    swap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_sel == ALU_SWAP) |=> $stable(flags_q) && res_wr);

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && flag_set_en && !flag_clr_en && (flag_idx < 3'd6) |=> flags_q[$past(flag_idx)]);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_wr && $stable(res_q));

    // R1
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && z_from_res |=> flags_q[F_Z] == (res_q == '0));

    // R14
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && writes_v |=> flags_q[F_S] == (flags_q[F_N] ^ flags_q[F_V]));

endmodule

bind alu8_unit alu8_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .flag_set_en (flag_set_en),
    .flag_clr_en (flag_clr_en),
    .flag_idx    (flag_idx),
    .res_q       (res_q),
    .res_wr      (res_wr),
    .flags_q     (flags_q)
);

// File: tb/alu8_unit_tb_top.sv
`timescale 1ns/1ps
module alu8_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       flag_set_en = 1'b0;
    logic       flag_clr_en = 1'b0;
    logic [2:0] flag_idx = '0;
    logic [7:0] res_q;
    logic       res_wr;
    logic [5:0] flags_q;

    int         n_chk = 0;
    int         n_err = 0;
    logic [5:0] exp_f = '0;
    logic [7:0] exp_r = '0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;

    alu8_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_sel      (op_sel),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .flag_set_en (flag_set_en),
        .flag_clr_en (flag_clr_en),
        .flag_idx    (flag_idx),
        .res_q       (res_q),
        .res_wr      (res_wr),
        .flags_q     (flags_q)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sg(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // expected behaviour, written from the requirements
    task automatic model(input int op, input int a, input int b, output bit wr);
        int  x, y, ci, t, sv, r;
        bit  c, hh, v, n, z;
        bit  [5:0] m, nv;
        r = a; c = exp_f[0]; hh = exp_f[5]; v = 1'b0; m = '0; wr = 1'b0;
        case (op)
            0, 1, 2, 3, 4, 5, 10: begin
                if (op == 10) begin x = 0; y = a; ci = 0; end
                else begin
                    x = a; y = b;
                    ci = (op == 1 || op == 3 || op == 5) ? int'(exp_f[0]) : 0;
                end
                if (op <= 1) begin
                    t = x + y + ci; c = (t > 255);
                    hh = ((x % 16) + (y % 16) + ci) > 15;
                    sv = sg(x) + sg(y) + ci;
                end else begin
                    t = x - y - ci; c = (t < 0);
                    hh = ((x % 16) - (y % 16) - ci) < 0;
                    sv = sg(x) - sg(y) - ci;
                end
                r = t & 255; v = (sv > 127) || (sv < -128);
                m = 6'b111111; wr = !(op == 4 || op == 5);
            end
            6: begin r = a & b; m = 6'b011110; wr = 1; end
            7: begin r = a | b; m = 6'b011110; wr = 1; end
            8: begin r = a ^ b; m = 6'b011110; wr = 1; end
            9: begin r = 255 - a; c = 1; m = 6'b011111; wr = 1; end
            11: begin r = (a + 1) & 255; v = (a == 127); m = 6'b011110; wr = 1; end
            12: begin r = (a + 255) & 255; v = (a == 128); m = 6'b011110; wr = 1; end
            13: begin c = a > 127; r = (a * 2) & 255; end
            14: begin r = ((a * 2) & 255) + int'(exp_f[0]); c = a > 127; end
            15: begin c = a % 2; r = a / 2; end
            16: begin r = a / 2 + int'(exp_f[0]) * 128; c = a % 2; end
            17: begin r = a / 2 + (a & 128); c = a % 2; end
            18: begin r = (a % 16) * 16 + a / 16; wr = 1; end
            default: ;
        endcase
        n = (r > 127);
        z = (r == 0);
        if (op == 3 || op == 5) z = z && exp_f[1];
        if (op >= 13 && op <= 17) begin v = n ^ c; m = 6'b011111; wr = 1; end
        nv = {hh, n ^ v, v, n, z, c};
        exp_f = (exp_f & ~m) | (nv & m);
        if (wr) exp_r = r[7:0];
    endtask

    task automatic do_op(string req, int op, int a, int b);
        bit wr;
        model(op, a, b, wr);
        op_valid = 1'b1; op_sel = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0;
        check(req, "result", int'(res_q), int'(exp_r));
        check(req, "res_wr", int'(res_wr), int'(wr));
        check(req, "flags", int'(flags_q), int'(exp_f));
    endtask

    task automatic fport(string req, bit s, bit c, int idx);
        flag_set_en = s; flag_clr_en = c; flag_idx = idx[2:0];
        @(posedge clk); @(negedge clk);
        flag_set_en = 1'b0; flag_clr_en = 1'b0;
        if ((s != c) && idx < 6) exp_f[idx] = s;
        check(req, "flags", int'(flags_q), int'(exp_f));
        check(req, "res_wr", int'(res_wr), 0);
    endtask

    task automatic preset(logic [5:0] val);
        for (int i = 0; i < 6; i++) fport("R11", val[i], !val[i], i);
    endtask

    task automatic t_reset;
        check("R13", "result", int'(res_q), 0);
        check("R13", "res_wr", int'(res_wr), 0);
        check("R13", "flags", int'(flags_q), 0);
    endtask

    task automatic t_add;
        do_op("R1", 0, 8'h0F, 8'h01);
        do_op("R1", 0, 8'h7F, 8'h01);
        do_op("R1", 0, 8'hFF, 8'h01);
        do_op("R1", 1, 8'h10, 8'h20);
        do_op("R14", 0, 8'h80, 8'h80);
    endtask

    task automatic t_sub;
        do_op("R2", 2, 8'h10, 8'h01);
        do_op("R2", 2, 8'h00, 8'h01);
        do_op("R2", 3, 8'h05, 8'h02);
        do_op("R2", 2, 8'h80, 8'h01);
    endtask

    task automatic t_cmp;
        do_op("R3", 4, 8'h34, 8'h34);
        do_op("R4", 5, 8'h12, 8'h12);
        do_op("R3", 4, 8'h35, 8'h34);
        do_op("R4", 5, 8'h12, 8'h12);
        do_op("R4", 3, 8'h09, 8'h09);
        do_op("R3", 5, 8'h01, 8'h02);
    endtask

    task automatic t_logic;
        preset(6'b100001);
        do_op("R5", 6, 8'hF0, 8'h0F);
        do_op("R5", 7, 8'h80, 8'h01);
        do_op("R5", 8, 8'hAA, 8'h55);
    endtask

    task automatic t_incdec;
        preset(6'b000001);
        do_op("R6", 11, 8'h7F, 0);
        do_op("R6", 11, 8'hFF, 0);
        do_op("R6", 12, 8'h80, 0);
        do_op("R6", 12, 8'h00, 0);
    endtask

    task automatic t_comneg;
        do_op("R7", 9, 8'h55, 0);
        do_op("R7", 10, 8'h00, 0);
        do_op("R7", 10, 8'h80, 0);
        do_op("R7", 10, 8'h01, 0);
    endtask

    task automatic t_shl;
        preset(6'b100000);
        do_op("R8", 13, 8'h81, 0);
        do_op("R8", 14, 8'h40, 0);
        do_op("R8", 14, 8'h80, 0);
    endtask

    task automatic t_shr;
        preset(6'b000001);
        do_op("R9", 16, 8'h02, 0);
        do_op("R9", 15, 8'h01, 0);
        do_op("R9", 17, 8'h81, 0);
        do_op("R9", 16, 8'h00, 0);
    endtask

    task automatic t_swap;
        preset(6'b101010);
        do_op("R10", 18, 8'hA5, 0);
    endtask

    task automatic t_flagports;
        preset(6'b000000);
        fport("R11", 1, 0, 5);
        fport("R11", 1, 0, 2);
        fport("R11", 0, 1, 5);
        fport("R11", 1, 1, 0);
        fport("R11", 1, 0, 6);
        fport("R11", 1, 0, 7);
        flag_set_en = 1'b1; flag_idx = 3'd0;
        do_op("R11", 18, 8'h3C, 0);
        flag_set_en = 1'b0;
    endtask

    task automatic t_idle;
        do_op("R12", 25, 8'hFF, 8'hFF);
        do_op("R12", 31, 8'h00, 8'h00);
        op_sel = 5'd0; opnd_a = 8'hFF; opnd_b = 8'h01;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            check("R12", "idle res_wr", int'(res_wr), 0);
            check("R12", "idle result", int'(res_q), int'(exp_r));
            check("R12", "idle flags", int'(flags_q), int'(exp_f));
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_add;
        t_sub;
        t_cmp;
        t_logic;
        t_incdec;
        t_comneg;
        t_shl;
        t_shr;
        t_swap;
        t_flagports;
        t_idle;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule